// File: doc/BRIEF.md
# Dual Down-Counting Register Timer

This block is a small register-mapped timer with two independent channels. Each channel owns a down-counter of `CNT_W` bits, a reload value and a control word. The control word holds a run bit, an interrupt-enable bit, a repeat-mode bit and a clock divider field. A counter steps once every `div + 1` cycles of the shared clock. When it runs out, it either reloads and keeps going (repeat mode) or parks at zero and drops its run bit (single-shot mode).

Both channels report expiry into one shared pending register. Software clears a pending flag by writing a one to its bit. Each channel drives its own interrupt line, which is high while its pending flag is set and its interrupt-enable bit is on. Software uses the block through a plain 32-bit port with word addresses: writes are one-cycle strobes and reads return data combinationally. The live count of either channel can be read at any time, so a channel left in repeat mode from the all-ones value serves as a free-running time base.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, every word address (0..7) reads zero and both interrupt lines are low.
- R2: The control words sit at word address 0 (channel 0) and word address 1 (channel 1). Bit 30 is run, bit 29 is interrupt enable, bit 27 is repeat mode (1 = repeat, 0 = single-shot), and bits `PSC_W-1:0` are the divider. All other bits read zero.
- R3: Reload values sit at word addresses 2 and 3. Live counts sit at word addresses 4 and 5 and are read-only: writes to them are ignored. Setting run after a reload-value write copies the reload value into the live count.
- R4: With divider P and reload value N ≥ 1, a started channel expires exactly N·(P+1) cycles after the clock edge that set run.
- R5: In single-shot mode, expiry leaves the live count at zero and clears run. No further expiry follows.
- R6: In repeat mode, expiry reloads the live count from the reload value and counting continues, so expiries repeat every N·(P+1) cycles.
- R7: Clearing run freezes the live count. Setting run again, with no reload-value write in between, resumes from the frozen value.
- R8: The pending register is at word address 6, with channel 0 at bit 0 and channel 1 at bit 1. Writing a 1 to a bit clears it, writing 0 leaves it unchanged, and writing 0x1F clears every flag.
- R9: An interrupt line is high exactly while its channel's pending flag is set and its interrupt-enable bit is 1.
- R10: When an expiry and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R11: A channel in repeat mode with interrupt enable off and reload value 0xFFFFFF runs freely downward from 0xFFFFFF, losing one per step, and its interrupt line stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | 3 | Word address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq | output | 2 | Interrupt line per channel, bit 0 for channel 0 |

## Verification
The bench builds the block with the full 24-bit counter and a 3-bit divider field. The small divider makes it practical to sweep every divider value against several reload values in single-shot mode and compare each expiry cycle against N·(P+1). The full counter width makes it possible to start the free-running all-ones case directly. The bench also lines up a clearing write with a repeat-mode expiry edge, and it checks halt and resume against exact step counts.

// File: rtl/tmr_pkg.sv
`timescale 1ns/100ps
package tmr_pkg;
   localparam int DATA_W      = 32;
   localparam int NUM_CH      = 2;
   localparam int AW          = 3;
   // Control word bit positions (software-visible layout)
   localparam int CTL_RUN_BIT = 30;
   localparam int CTL_IE_BIT  = 29;
   localparam int CTL_REP_BIT = 27;
   // Word address bases; channel c is at base + c
   localparam logic [AW-1:0] A_CTL_BASE  = 3'd0;
   localparam logic [AW-1:0] A_LOAD_BASE = 3'd2;
   localparam logic [AW-1:0] A_CNT_BASE  = 3'd4;
   localparam logic [AW-1:0] A_PEND      = 3'd6;

   typedef struct packed {
      logic run;
      logic ie;
      logic rep;
   } chan_mode_t;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/100ps
module tmr_prescaler #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);
   logic [PSC_W-1:0] phase_q;

   // Tick on the last phase; >= keeps a lowered divider from stalling
   assign tick = run && (phase_q >= div);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart) begin
         phase_q <= '0;
      end else if (run) begin
         if (phase_q >= div) phase_q <= '0;
         else                phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/100ps
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W = 24,
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic             load_we,
   input  logic             run_in,
   input  logic             ie_in,
   input  logic             rep_in,
   input  logic [PSC_W-1:0] div_in,
   input  logic [CNT_W-1:0] load_in,
   output chan_mode_t       mode_o,
   output logic [PSC_W-1:0] div_o,
   output logic [CNT_W-1:0] load_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   chan_mode_t       mode_q;
   logic [PSC_W-1:0] div_q;
   logic [CNT_W-1:0] load_q;
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             start;
   logic             tick;
   logic             last;

   // A run request after a fresh reload value (or after a single-shot end) restarts the count
   assign start = ctl_we && run_in && armed_q;
   assign last  = (cnt_q <= ONE);

   tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (mode_q.run),
      .restart (start),
      .div     (div_q),
      .tick    (tick)
   );

   assign expire_o = tick && !start && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= '0;
         div_q   <= '0;
         load_q  <= '0;
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else begin
         if (load_we) begin
            load_q  <= load_in;
            armed_q <= 1'b1;
         end
         if (ctl_we) begin
            mode_q.run <= run_in;
            mode_q.ie  <= ie_in;
            mode_q.rep <= rep_in;
            div_q      <= div_in;
         end
         if (start) begin
            cnt_q   <= load_q;
            armed_q <= 1'b0;
         end else if (tick) begin
            if (last) begin
               if (mode_q.rep) begin
                  cnt_q <= load_q;
               end else begin
                  cnt_q   <= '0;
                  armed_q <= 1'b1;
                  if (!ctl_we) mode_q.run <= 1'b0;
               end
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end

   assign mode_o = mode_q;
   assign div_o  = div_q;
   assign load_o = load_q;
   assign cnt_o  = cnt_q;
endmodule

// File: rtl/tmr_irq_status.sv
`timescale 1ns/100ps
module tmr_irq_status #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_we,
   input  logic [NUM_CH-1:0] clr_bits,
   input  logic [NUM_CH-1:0] set_bits,
   input  logic [NUM_CH-1:0] ie,
   output logic [NUM_CH-1:0] flags,
   output logic [NUM_CH-1:0] irq
);
   logic [NUM_CH-1:0] flags_q;
   logic [NUM_CH-1:0] clr_mask;

   assign clr_mask = clr_we ? clr_bits : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_mask) | set_bits;  // a new expiry beats a clear
   end

   assign flags = flags_q;
   assign irq   = flags_q & ie;
endmodule

// File: rtl/dual_down_timer.sv
`timescale 1ns/100ps
module dual_down_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W = 24,
   parameter int PSC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        addr,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   output logic [1:0]        irq
);
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("dual_down_timer: CNT_W must be 1..32");
   end
   if (PSC_W < 1 || PSC_W > CTL_REP_BIT) begin : g_bad_psc
      $error("dual_down_timer: PSC_W must be 1..27");
   end

   chan_mode_t                    mode_v [NUM_CH];
   logic [NUM_CH-1:0][PSC_W-1:0]  div_v;
   logic [NUM_CH-1:0][CNT_W-1:0]  load_v;
   logic [NUM_CH-1:0][CNT_W-1:0]  cnt_v;
   logic [NUM_CH-1:0]             expire_v;
   logic [NUM_CH-1:0]             run_v;
   logic [NUM_CH-1:0]             ie_v;
   logic [NUM_CH-1:0]             rep_v;
   logic [NUM_CH-1:0]             flags_q;
   logic                          unused_wd;

   assign unused_wd = ^wr_data;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [AW-1:0] CTL_A  = A_CTL_BASE  + AW'(c);
      localparam logic [AW-1:0] LOAD_A = A_LOAD_BASE + AW'(c);

      tmr_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctl_we   (wr_en && (addr == CTL_A)),
         .load_we  (wr_en && (addr == LOAD_A)),
         .run_in   (wr_data[CTL_RUN_BIT]),
         .ie_in    (wr_data[CTL_IE_BIT]),
         .rep_in   (wr_data[CTL_REP_BIT]),
         .div_in   (wr_data[PSC_W-1:0]),
         .load_in  (wr_data[CNT_W-1:0]),
         .mode_o   (mode_v[c]),
         .div_o    (div_v[c]),
         .load_o   (load_v[c]),
         .cnt_o    (cnt_v[c]),
         .expire_o (expire_v[c])
      );

      assign run_v[c] = mode_v[c].run;
      assign ie_v[c]  = mode_v[c].ie;
      assign rep_v[c] = mode_v[c].rep;
   end

   tmr_irq_status #(.NUM_CH(NUM_CH)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_we   (wr_en && (addr == A_PEND)),
      .clr_bits (wr_data[NUM_CH-1:0]),
      .set_bits (expire_v),
      .ie       (ie_v),
      .flags    (flags_q),
      .irq      (irq)
   );

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (addr == A_CTL_BASE + AW'(c)) begin
            rd_data[CTL_RUN_BIT] = run_v[c];
            rd_data[CTL_IE_BIT]  = ie_v[c];
            rd_data[CTL_REP_BIT] = rep_v[c];
            rd_data[PSC_W-1:0]   = div_v[c];
         end
         if (addr == A_LOAD_BASE + AW'(c)) rd_data[CNT_W-1:0] = load_v[c];
         if (addr == A_CNT_BASE + AW'(c))  rd_data[CNT_W-1:0] = cnt_v[c];
      end
      if (addr == A_PEND) rd_data[NUM_CH-1:0] = flags_q;
   end
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/100ps
module tmr_checker
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int CNT_W  = 24
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            wr_en,
   input logic [AW-1:0]                   addr,
   input logic [NUM_CH-1:0]               clr_bits,
   input logic [NUM_CH-1:0]               irq,
   input logic [NUM_CH-1:0]               flags,
   input logic [NUM_CH-1:0]               expire,
   input logic [NUM_CH-1:0]               run_v,
   input logic [NUM_CH-1:0]               ie_v,
   input logic [NUM_CH-1:0]               rep_v,
   input logic [NUM_CH-1:0][CNT_W-1:0]    cnt_v
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      localparam logic [AW-1:0] CTL_A = A_CTL_BASE + AW'(c);
      logic ctl_wr;
      logic pend_clr;
      assign ctl_wr   = wr_en && (addr == CTL_A);
      assign pend_clr = wr_en && (addr == A_PEND) && clr_bits[c];

      // R7: a stopped channel keeps its count unless its control word is written
      p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_v[c] && !ctl_wr) |=> $stable(cnt_v[c]));

      // R5: single-shot expiry drops run
      p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (expire[c] && !rep_v[c] && !ctl_wr) |=> !run_v[c]);

      // R10: an expiry always leaves the flag set, even against a clear
      p_expire_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
         expire[c] |=> flags[c]);

      // R8: clearing write without a fresh expiry drops the flag
      p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_clr && !expire[c]) |=> !flags[c]);

      // R8: a flag persists until cleared
      p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[c] && !pend_clr) |=> flags[c]);

      // R9: an enabled expiry raises the line on the next cycle
      p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (expire[c] && ie_v[c] && !ctl_wr) |=> irq[c]);
   end
endmodule

bind dual_down_timer tmr_checker #(.NUM_CH(2), .CNT_W(CNT_W)) u_tmr_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .clr_bits (wr_data[1:0]),
   .irq      (irq),
   .flags    (flags_q),
   .expire   (expire_v),
   .run_v    (run_v),
   .ie_v     (ie_v),
   .rep_v    (rep_v),
   .cnt_v    (cnt_v)
);

// File: tb/test_dual_down_timer.sv
`timescale 1ns/100ps
module test_dual_down_timer;
   localparam int CNT_W = 24;
   localparam int PSC_W = 3;
   localparam logic [31:0] RUN = 32'h4000_0000;
   localparam logic [31:0] IE  = 32'h2000_0000;
   localparam logic [31:0] REP = 32'h0800_0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [2:0]  addr;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic [1:0]  irq;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   dual_down_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_dual_down_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
      end
   endtask

   // Write lands on the next rising edge; returns just after that edge's negedge
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      addr = a;
      #0.1;
      d = rd_data;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Count negedges until irq[ch] goes high
   task automatic time_irq(input int ch, input int limit, output int k);
      k = 0;
      for (int i = 1; i <= limit; i++) begin
         @(negedge clk);
         if (irq[ch] && k == 0) k = i;
         if (k != 0) break;
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int k;
      rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         chk("R1 reset read", v, 32'h0);
      end
      chk("R1 irq after reset", {30'h0, irq}, 32'h0);

      // R2: control readback masks undefined bits
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v);
      chk("R2 control readback", v, 32'h6800_0007);
      wr(3'd0, 32'h0);
      rd(3'd0, v);
      chk("R2 control cleared", v, 32'h0);
      wr(3'd6, 32'h1F);

      // R3: live count is read-only
      wr(3'd4, 32'h0000_0123);
      rd(3'd4, v);
      chk("R3 count write ignored", v, 32'h0);

      // R4/R5: sweep divider and reload value in single-shot mode
      for (int p = 0; p < 8; p++) begin
         for (int n = 1; n <= 4; n++) begin
            wr(3'd2, 32'(n));
            wr(3'd0, RUN | IE | 32'(p));
            time_irq(0, 60, k);
            chk("R4 expiry cycle", 32'(k), 32'(n * (p + 1)));
            rd(3'd0, v);
            chk("R5 run dropped", v, IE | 32'(p));
            rd(3'd4, v);
            chk("R5 count parked", v, 32'h0);
            wr(3'd6, 32'h1);
         end
      end
      wait_cyc(20);
      rd(3'd6, v);
      chk("R5 no further expiry", v, 32'h0);
      chk("R5 irq quiet", {30'h0, irq}, 32'h0);
      wr(3'd0, 32'h0);

      // R3/R11: free-running channel 1
      wr(3'd3, 32'h00FF_FFFF);
      wr(3'd1, RUN | REP);
      rd(3'd5, v);
      chk("R3 load on start", v, 32'h00FF_FFFF);
      wait_cyc(10);
      rd(3'd5, v);
      chk("R11 free run decrement", v, 32'h00FF_FFFF - 10);
      chk("R11 irq low", {31'h0, irq[1]}, 32'h0);

      // R7: halt and resume
      wr(3'd1, REP);
      rd(3'd5, v);
      chk("R7 halted value", v, 32'h00FF_FFFF - 11);
      wait_cyc(5);
      rd(3'd5, v);
      chk("R7 hold while halted", v, 32'h00FF_FFFF - 11);
      wr(3'd1, RUN | REP);
      rd(3'd5, v);
      chk("R7 resume no reload", v, 32'h00FF_FFFF - 11);
      wait_cyc(4);
      rd(3'd5, v);
      chk("R7 resumed count", v, 32'h00FF_FFFF - 15);
      wr(3'd1, 32'h0);

      // R6: repeat mode, divider 1, reload 2 -> period 4
      wr(3'd3, 32'd2);
      wr(3'd1, RUN | IE | REP | 32'd1);
      time_irq(1, 20, k);
      chk("R6 first expiry", 32'(k), 32'd4);
      wr(3'd6, 32'h2);
      chk("R8 clear drops irq", {31'h0, irq[1]}, 32'h0);
      time_irq(1, 20, k);
      chk("R6 second expiry", 32'(k), 32'd3);
      rd(3'd5, v);
      chk("R6 reloaded count", v, 32'd2);
      wr(3'd1, 32'h0);
      wr(3'd6, 32'h2);

      // R10: clear coinciding with an expiry
      wr(3'd2, 32'd3);
      wr(3'd0, RUN | IE | REP);
      wait_cyc(3);
      wr(3'd6, 32'h1);
      rd(3'd6, v);
      chk("R8 clear between expiries", v & 32'h1, 32'h0);
      @(negedge clk);
      wr(3'd6, 32'h1);
      rd(3'd6, v);
      chk("R10 expiry beats clear", v & 32'h1, 32'h1);
      wr(3'd0, 32'h0);
      wr(3'd6, 32'h1);

      // R8/R9: both flags, gating and clearing
      wr(3'd2, 32'd1);
      wr(3'd0, RUN);
      wr(3'd3, 32'd1);
      wr(3'd1, RUN);
      wait_cyc(3);
      rd(3'd6, v);
      chk("R8 both flags", v, 32'h3);
      chk("R9 masked irq", {30'h0, irq}, 32'h0);
      wr(3'd0, IE);
      chk("R9 enable exposes flag", {30'h0, irq}, 32'h1);
      wr(3'd6, 32'h0);
      rd(3'd6, v);
      chk("R8 zero write keeps", v, 32'h3);
      wr(3'd6, 32'h1);
      rd(3'd6, v);
      chk("R8 clear bit0 only", v, 32'h2);
      chk("R9 irq follows flag", {30'h0, irq}, 32'h0);
      wr(3'd6, 32'h1F);
      rd(3'd6, v);
      chk("R8 clear all", v, 32'h0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule